// File: doc/BRIEF.md
# Three-Term Summing Phase Accumulator

This block is the phase engine of a numerically controlled oscillator. Each clock it forms a phase increment by adding three frequency terms modulo 2^48: a 48-bit center word, a 48-bit offset word and a 40-bit tuning word. Each term has its own enable input, and a term whose enable is low adds zero. The increment is integrated by a 48-bit accumulator. The upper 24 phase bits are presented as an address for a sine amplitude table.

The whole path from the input pins to the accumulator has a fixed latency of fourteen clock cycles. A change on any word or enable therefore alters the phase stream exactly fourteen cycles later. Switching the offset enable on and off is enough to move between two preset frequencies, and the timing of that switch is known in advance.

A valid flag marks the point where the accumulator begins to integrate increments taken after reset. The sum can be read as two's complement, so a negative offset lowers the center frequency.

Top module: `nco3_core`

## Requirements
- R1: The increment applied to the accumulator is (C·ctr_en + O·ofs_en + T·tune_en) mod 2^48. Here C is ctr_word, O is ofs_word and T is tune_word zero-extended so that it occupies sum bits 39:0. Example: T = 0xFF_FFFF_FFFF with C = 1 and both enabled gives an increment of 2^40, so phase_addr advances by 0x010000 each cycle.
- R2: Each of ctr_en, ofs_en and tune_en zeroes only its own term. With all three low, phase_addr stops changing once the pipeline has drained.
- R3: The accumulator wraps modulo 2^48 and phase_addr is accumulator bits 47:24. An increment of 0x8000_0000_0000 makes phase_addr alternate between 0x800000 and 0x000000.
- R4: The sum wraps as two's complement. C = 0x4000_0000_0000 with O = 0xC000_0000_0000 gives a zero increment, and phase_addr holds still.
- R5: Inputs sampled at rising edge k are added into the accumulator at rising edge k+14. This holds for the offset enable as well: after ofs_en rises, phase_addr is unchanged for 14 more falling edges and moves on the 15th.
- R6: A synchronous active-high rst clears the accumulator and every pipeline stage. While rst is high, phase_addr reads 0 and phase_vld reads 0.
- R7: phase_vld goes high at the 15th rising edge after rst is released and stays high until the next reset. While phase_vld is low, phase_addr stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_word | input | 48 | Center frequency term |
| ofs_word | input | 48 | Offset frequency term |
| tune_word | input | 40 | Tuning frequency term, aligned to bits 39:0 |
| ctr_en | input | 1 | Enables the center term |
| ofs_en | input | 1 | Enables the offset term |
| tune_en | input | 1 | Enables the tuning term |
| phase_addr | output | 24 | Upper phase bits, used as a lookup address |
| phase_vld | output | 1 | Accumulator is integrating post-reset increments |

## Verification
The hardest case to reach from the ports is the exact cycle in which an offset-enable toggle shows up in the phase. The accumulator moves every cycle, so an off-by-one in latency is hidden unless the phase is otherwise frozen. The stimulus first sets the center term to zero and leaves the pipeline to drain, so the phase is constant. It then raises only the offset enable, using an offset word that moves the address by exactly one per cycle, and checks each of the following falling edges. A cycle-level reference model with a fourteen-deep increment history also tracks every run, including runs of random words and enables.

// File: rtl/nco3_pkg.sv
package nco3_pkg;
   localparam int unsigned NCO3_ACC_W  = 48;
   localparam int unsigned NCO3_TUNE_W = 40;
   localparam int unsigned NCO3_ADDR_W = 24;
   localparam int unsigned NCO3_LAT    = 14;
endpackage

// File: rtl/nco3_term_gate.sv
module nco3_term_gate #(
   parameter int unsigned IN_W  = 40,
   parameter int unsigned OUT_W = 48
) (
   input  logic [IN_W-1:0]  term_in,
   input  logic             term_en,
   output logic [OUT_W-1:0] term_out
);
   logic [OUT_W-1:0] ext;

   generate
      if (IN_W == OUT_W) begin : g_same
         assign ext = term_in;
      end else begin : g_pad
         assign ext = {{(OUT_W-IN_W){1'b0}}, term_in};
      end
   endgenerate

   assign term_out = term_en ? ext : '0;
endmodule

// File: rtl/nco3_inc_sum.sv
module nco3_inc_sum #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_term,
   input  logic [W-1:0] b_term,
   input  logic [W-1:0] c_term,
   output logic [W-1:0] inc_q,
   output logic         inc_vld_q
);
   logic [W-1:0] sum_d;

   assign sum_d = a_term + b_term + c_term;

   always_ff @(posedge clk) begin
      if (rst) begin
         inc_q     <= '0;
         inc_vld_q <= 1'b0;
      end else begin
         inc_q     <= sum_d;
         inc_vld_q <= 1'b1;
      end
   end
endmodule

// File: rtl/nco3_pipe_delay.sv
module nco3_pipe_delay #(
   parameter int unsigned W     = 49,
   parameter int unsigned DEPTH = 13
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign d_out = d_in;
      end else begin : g_regs
         logic [W-1:0] stage_q [DEPTH];
         for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
               always_ff @(posedge clk) begin
                  if (rst) stage_q[i] <= '0;
                  else     stage_q[i] <= d_in;
               end
            end else begin : g_tail
               always_ff @(posedge clk) begin
                  if (rst) stage_q[i] <= '0;
                  else     stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign d_out = stage_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/nco3_phase_acc.sv
module nco3_phase_acc #(
   parameter int unsigned ACC_W  = 48,
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ACC_W-1:0]  inc,
   input  logic              inc_vld,
   output logic [ADDR_W-1:0] addr,
   output logic              vld
);
   logic [ACC_W-1:0] acc_q;
   logic             vld_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         vld_q <= 1'b0;
      end else begin
         acc_q <= acc_q + inc;
         vld_q <= inc_vld;
      end
   end

   assign addr = acc_q[ACC_W-1 -: ADDR_W];
   assign vld  = vld_q;
endmodule

// File: rtl/nco3_core.sv
module nco3_core #(
   parameter int unsigned ACC_W   = nco3_pkg::NCO3_ACC_W,
   parameter int unsigned TUNE_W  = nco3_pkg::NCO3_TUNE_W,
   parameter int unsigned ADDR_W  = nco3_pkg::NCO3_ADDR_W,
   parameter int unsigned LATENCY = nco3_pkg::NCO3_LAT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ACC_W-1:0]  ctr_word,
   input  logic [ACC_W-1:0]  ofs_word,
   input  logic [TUNE_W-1:0] tune_word,
   input  logic              ctr_en,
   input  logic              ofs_en,
   input  logic              tune_en,
   output logic [ADDR_W-1:0] phase_addr,
   output logic              phase_vld
);
   localparam int unsigned DLY_DEPTH = LATENCY - 1;
   localparam int unsigned PIPE_W    = ACC_W + 1;

   generate
      if (LATENCY < 1) begin : g_bad_lat
         $error("nco3_core: LATENCY must be at least 1");
      end
      if (TUNE_W > ACC_W) begin : g_bad_tune
         $error("nco3_core: TUNE_W must not exceed ACC_W");
      end
      if (ADDR_W > ACC_W || ADDR_W == 0) begin : g_bad_addr
         $error("nco3_core: ADDR_W must be in 1..ACC_W");
      end
   endgenerate

   logic [ACC_W-1:0]  ctr_g, ofs_g, tune_g;
   logic [ACC_W-1:0]  inc_q;
   logic              inc_vld_q;
   logic [PIPE_W-1:0] pipe_out;

   nco3_term_gate #(.IN_W(ACC_W), .OUT_W(ACC_W)) i_gate_ctr (
      .term_in(ctr_word), .term_en(ctr_en), .term_out(ctr_g));
   nco3_term_gate #(.IN_W(ACC_W), .OUT_W(ACC_W)) i_gate_ofs (
      .term_in(ofs_word), .term_en(ofs_en), .term_out(ofs_g));
   nco3_term_gate #(.IN_W(TUNE_W), .OUT_W(ACC_W)) i_gate_tune (
      .term_in(tune_word), .term_en(tune_en), .term_out(tune_g));

   nco3_inc_sum #(.W(ACC_W)) i_sum (
      .clk(clk), .rst(rst),
      .a_term(ctr_g), .b_term(ofs_g), .c_term(tune_g),
      .inc_q(inc_q), .inc_vld_q(inc_vld_q));

   nco3_pipe_delay #(.W(PIPE_W), .DEPTH(DLY_DEPTH)) i_dly (
      .clk(clk), .rst(rst),
      .d_in({inc_vld_q, inc_q}), .d_out(pipe_out));

   nco3_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) i_acc (
      .clk(clk), .rst(rst),
      .inc(pipe_out[ACC_W-1:0]), .inc_vld(pipe_out[ACC_W]),
      .addr(phase_addr), .vld(phase_vld));
endmodule

// File: rtl/nco3_core_chk.sv
module nco3_core_chk #(
   parameter int unsigned ADDR_W  = 24,
   parameter int unsigned LATENCY = 14
) (
   input logic              clk,
   input logic              rst,
   input logic              ctr_en,
   input logic              ofs_en,
   input logic              tune_en,
   input logic [ADDR_W-1:0] phase_addr,
   input logic              phase_vld
);
   int unsigned idle_cnt;
   logic        seen_edge;

   always_ff @(posedge clk) begin
      seen_edge <= 1'b1;
      if (rst || ctr_en || ofs_en || tune_en) idle_cnt <= 0;
      else if (idle_cnt < LATENCY)            idle_cnt <= idle_cnt + 1;
   end

   // R6: reset clears the outputs on the following cycle
   a_r6_reset_clears: assert property (@(posedge clk)
      rst |=> (phase_addr == '0 && !phase_vld));

   // R7: valid never drops outside reset
   a_r7_vld_sticky: assert property (@(posedge clk) disable iff (rst)
      phase_vld |=> phase_vld);

   // R7: address held at zero while not valid
   a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
      (seen_edge && !phase_vld) |-> phase_addr == '0);

   // R2: all enables low for a full latency window freezes the phase
   a_r2_all_off_frozen: assert property (@(posedge clk) disable iff (rst)
      (idle_cnt >= LATENCY) |=> $stable(phase_addr));
endmodule

bind nco3_core nco3_core_chk #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) i_chk (
   .clk(clk), .rst(rst), .ctr_en(ctr_en), .ofs_en(ofs_en), .tune_en(tune_en),
   .phase_addr(phase_addr), .phase_vld(phase_vld));

// File: tb/test_nco3_core.sv
`timescale 1ns/1ps
module test_nco3_core;
   localparam int LAT = 14;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [47:0] ctr_word = '0, ofs_word = '0;
   logic [39:0] tune_word = '0;
   logic        ctr_en = 1'b0, ofs_en = 1'b0, tune_en = 1'b0;
   logic [23:0] phase_addr;
   logic        phase_vld;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   nco3_core i_nco3_core (
      .clk(clk), .rst(rst),
      .ctr_word(ctr_word), .ofs_word(ofs_word), .tune_word(tune_word),
      .ctr_en(ctr_en), .ofs_en(ofs_en), .tune_en(tune_en),
      .phase_addr(phase_addr), .phase_vld(phase_vld));

   // reference model: acc(n) = acc(n-1) + inc(n-14)
   logic [47:0] m_hist [LAT];
   logic        m_hv   [LAT];
   logic [47:0] m_acc;
   logic        m_vld;

   function automatic logic [47:0] ref_inc();
      logic [47:0] s;
      s = (ctr_en ? ctr_word : 48'd0) + (ofs_en ? ofs_word : 48'd0)
        + (tune_en ? {8'd0, tune_word} : 48'd0);
      return s;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_acc <= '0;
         m_vld <= 1'b0;
         for (int i = 0; i < LAT; i++) begin
            m_hist[i] <= '0;
            m_hv[i]   <= 1'b0;
         end
      end else begin
         m_acc <= m_acc + m_hist[LAT-1];
         m_vld <= m_hv[LAT-1];
         m_hist[0] <= ref_inc();
         m_hv[0]   <= 1'b1;
         for (int i = 1; i < LAT; i++) begin
            m_hist[i] <= m_hist[i-1];
            m_hv[i]   <= m_hv[i-1];
         end
      end
   end

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp_v, $time);
      end
   endtask

   task automatic run_model(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(req, phase_addr, m_acc[47:24]);
         chk(req, {23'd0, phase_vld}, {23'd0, m_vld});
      end
   endtask

   task automatic set_all(input logic [47:0] c, input logic [47:0] o, input logic [39:0] t,
                          input logic ce, input logic oe, input logic te);
      ctr_word = c; ofs_word = o; tune_word = t;
      ctr_en = ce; ofs_en = oe; tune_en = te;
   endtask

   // R6, R7
   task automatic t_reset();
      rst = 1'b1;
      set_all(48'h1234_5678_9ABC, 48'h1, 40'h5, 1'b1, 1'b1, 1'b1);
      repeat (3) begin
         @(negedge clk);
         chk("R6", phase_addr, 24'd0);
         chk("R6", {23'd0, phase_vld}, 24'd0);
      end
      rst = 1'b0;
      for (int i = 1; i <= 16; i++) begin
         @(negedge clk);
         chk("R7", {23'd0, phase_vld}, (i >= 15) ? 24'd1 : 24'd0);
         if (i < 15) chk("R7", phase_addr, 24'd0);
         chk("R7", phase_addr, m_acc[47:24]);
      end
   endtask

   // R1: tuning word alignment
   task automatic t_tune_align();
      logic [23:0] prev;
      set_all(48'd1, 48'd0, 40'hFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1);
      run_model(LAT + 2, "R1");
      prev = phase_addr;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R1", phase_addr, prev + 24'h010000);
         prev = phase_addr;
      end
   endtask

   // R2: each enable alone
   task automatic t_enables();
      set_all(48'h0000_0300_0000, 48'h0000_0050_0000, 40'h00_0700_0000, 1'b1, 1'b0, 1'b0);
      run_model(LAT + 4, "R2");
      ctr_en = 1'b0; ofs_en = 1'b1;
      run_model(LAT + 4, "R2");
      ofs_en = 1'b0; tune_en = 1'b1;
      run_model(LAT + 4, "R2");
      ctr_en = 1'b1; tune_en = 1'b0; ofs_en = 1'b1;
      run_model(LAT + 4, "R2");
      begin
         logic [23:0] held;
         ctr_en = 1'b0; ofs_en = 1'b0; tune_en = 1'b0;
         run_model(LAT + 2, "R2");
         held = phase_addr;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R2", phase_addr, held);
         end
      end
   endtask

   // R3: wrap at half scale
   task automatic t_wrap();
      logic [23:0] prev;
      set_all(48'h8000_0000_0000, 48'd0, 40'd0, 1'b1, 1'b0, 1'b0);
      run_model(LAT + 2, "R3");
      prev = phase_addr;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R3", phase_addr, prev ^ 24'h800000);
         prev = phase_addr;
      end
   endtask

   // R4: two's complement cancellation
   task automatic t_cancel();
      logic [23:0] held;
      set_all(48'h4000_0000_0000, 48'hC000_0000_0000, 40'd0, 1'b1, 1'b1, 1'b0);
      run_model(LAT + 2, "R4");
      held = phase_addr;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R4", phase_addr, held);
      end
   endtask

   // R5: offset enable latency
   task automatic t_ofs_latency();
      logic [23:0] held;
      set_all(48'd0, 48'h0000_0100_0000, 40'd0, 1'b0, 1'b0, 1'b0);
      run_model(LAT + 2, "R5");
      held = phase_addr;
      ofs_en = 1'b1;
      for (int i = 1; i <= 17; i++) begin
         @(negedge clk);
         if (i <= LAT) chk("R5", phase_addr, held);
         else          chk("R5", phase_addr, held + 24'(i - LAT));
      end
   endtask

   // R1, R5: random words and enables
   task automatic t_random();
      for (int k = 0; k < 40; k++) begin
         set_all({$urandom(), $urandom()} , {$urandom(), $urandom()}, {$urandom(), $urandom()},
                 1'($urandom()), 1'($urandom()), 1'($urandom()));
         run_model(1 + ($urandom() % 5), "R5");
      end
      run_model(LAT + 2, "R1");
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_tune_align();
      t_enables();
      t_wrap();
      t_cancel();
      t_ofs_latency();
      t_random();
      t_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule